// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer

This block turns one read strobe into the full beat schedule of a synchronous DRAM read. When a read is strobed it captures the starting column, the CAS latency, the burst-length code and the ordering flag. It then issues one column per clock and returns the addressed words from a small internal register file. The words appear on the data output after the captured latency, on consecutive cycles, and an output-enable frames them.

A burst of fixed length ends by itself. A full-page burst walks the whole row, wraps from the top column to column 0, and keeps going until the terminate input stops it. A fresh read strobe during a burst cuts the running burst off and starts the new sequence. Words already on their way through the latency pipeline are still delivered. The register file stands in for the memory array so that the sequencer can be checked by itself. After reset, each entry holds a word computed from its own column number.

Top module: `sdram_rd_burst_seq`

## Requirements
- R1: During and right after reset, `beat_col_valid` and `dq_oe` are low and `dq_out` is zero. A reset applied in the middle of a burst removes every pending beat.
- R2: A read strobe sampled at a clock edge makes `beat_col_valid` high in the following cycle, with `beat_col` equal to the strobed column. Each later beat of the same burst follows one cycle after the previous one, with no gaps.
- R3: The first data word is driven exactly CL cycles after the edge that sampled the read, where CL is the captured `cas_lat`. Codes 2 and 3 select latency 2 and 3, and codes 0 and 1 behave as latency 2.
- R4: Every driven data word equals the register-file entry of its beat column. After reset, entry c holds {c XOR 8'h5A, bitwise NOT c} (upper byte, lower byte).
- R5: `burst_code` sets the number of beats: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. Codes 4, 5 and 6 give 1 beat.
- R6: With `interleave` low and a fixed length L, beat k keeps the upper column bits of the start column. Its low log2(L) bits are (start + k) mod L.
- R7: With `interleave` high and a fixed length L, beat k keeps the upper column bits of the start column. Its low log2(L) bits are the start's low bits XOR k.
- R8: A full-page burst increments the whole column by one per beat, wraps from 255 to 0, and continues past 256 beats until terminated. In this mode `interleave` has no effect.
- R9: `term` high at an edge without a read strobe issues no further beat. Beats issued before that edge still deliver their data. It applies to any burst.
- R10: `dq_oe` is high exactly in the cycles that carry a burst word and drops in the cycle after the last one. `dq_out` is zero whenever `dq_oe` is low.
- R11: A read strobe during a running burst ends that burst. The next beat is the new start column, and the new burst's words follow its own latency after the words already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read strobe, one cycle per command |
| rd_col | input | 8 | Starting column, captured with the strobe |
| cas_lat | input | 2 | CAS latency code, captured with the strobe |
| burst_code | input | 3 | Burst-length code, captured with the strobe |
| interleave | input | 1 | Burst order: 0 sequential, 1 interleaved |
| term | input | 1 | Stops the running burst |
| beat_col | output | 8 | Column of the beat issued this cycle |
| beat_col_valid | output | 1 | A beat is issued this cycle |
| dq_out | output | 16 | Read data word |
| dq_oe | output | 1 | Data bus driven with a valid word |

## Verification
A wrong beat counter or mask shows at `beat_col` in the cycle right after the bad update: a column out of order, a beat too many, or a missing beat. Because this comes before the data, the bench checks every column on every cycle, against its own ordering formula. A latency tap or pipeline fault shows CL cycles later. It appears as `dq_oe` framing shifted by one cycle, or as `dq_out` carrying the word of a neighbouring column. Those words can be told apart, because each register-file word encodes its own address. Faults in stopping, in wrapping and in cutting off a burst are driven into view with a terminated fixed burst, with full-page runs across column 255 and past 256 beats, and with a read strobed in the middle of a burst.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef struct packed {
    logic       full;
    logic [1:0] len_log2;
  } burst_cfg_t;

  localparam logic [2:0] BCODE_FULL = 3'd7;

  function automatic burst_cfg_t decode_burst(input logic [2:0] code);
    burst_cfg_t c;
    c.full     = 1'b0;
    c.len_log2 = 2'd0;
    case (code)
      3'd1:       c.len_log2 = 2'd1;
      3'd2:       c.len_log2 = 2'd2;
      3'd3:       c.len_log2 = 2'd3;
      BCODE_FULL: c.full     = 1'b1;
      default:    c.len_log2 = 2'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sdram_rd_addr_gen.sv
module sdram_rd_addr_gen
  import sdram_rd_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [COL_W-1:0] rd_col,
  input  logic [2:0]       burst_code,
  input  logic             interleave,
  input  logic             term,
  output logic [COL_W-1:0] col_q,
  output logic             vld_q,
  output logic             act_q,
  output logic             full_q,
  output logic [COL_W-1:0] cnt_q,
  output logic [COL_W-1:0] mask_q
);

  function automatic logic [COL_W-1:0] len_mask(input burst_cfg_t c);
    if (c.full) return '1;
    return COL_W'((32'd1 << c.len_log2) - 32'd1);
  endfunction

  function automatic logic [COL_W-1:0] beat_column(
    input logic [COL_W-1:0] start,
    input logic [COL_W-1:0] cnt,
    input logic [COL_W-1:0] mask,
    input logic             ilv
  );
    logic [COL_W-1:0] low;
    low = ilv ? (start ^ cnt) : (start + cnt);
    return (start & ~mask) | (low & mask);
  endfunction

  burst_cfg_t       cfg_new;
  logic [COL_W-1:0] mask_new;
  logic [COL_W-1:0] start_q;
  logic             ilv_q;
  logic             last_beat;

  assign cfg_new   = decode_burst(burst_code);
  assign mask_new  = len_mask(cfg_new);
  assign last_beat = !full_q && (cnt_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      col_q   <= '0;
      vld_q   <= 1'b0;
    end else if (rd_req) begin
      start_q <= rd_col;
      mask_q  <= mask_new;
      ilv_q   <= interleave & !cfg_new.full;
      full_q  <= cfg_new.full;
      col_q   <= rd_col;
      vld_q   <= 1'b1;
      cnt_q   <= COL_W'(1);
      act_q   <= cfg_new.full | (mask_new != '0);
    end else if (act_q && !term) begin
      col_q   <= beat_column(start_q, cnt_q, mask_q, ilv_q);
      vld_q   <= 1'b1;
      cnt_q   <= cnt_q + COL_W'(1);
      act_q   <= !last_beat;
    end else begin
      vld_q   <= 1'b0;
      act_q   <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_rd_regfile.sv
module sdram_rd_regfile #(
  parameter int              COL_W = 8,
  parameter int              DW    = 16,
  parameter logic [COL_W-1:0] SALT = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);

  localparam int DEPTH = 1 << COL_W;

  function automatic logic [DW-1:0] seed_word(input logic [COL_W-1:0] c);
    return DW'({c ^ SALT, ~c});
  endfunction

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= seed_word(COL_W'(i));
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int DW     = 16,
  parameter int MAX_CL = 3,
  parameter int CLW    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [DW-1:0]  in_data,
  input  logic [CLW-1:0] cl_sel,
  output logic           out_vld,
  output logic [DW-1:0]  out_data
);

  logic [MAX_CL-1:0] v;
  logic [DW-1:0]     d [MAX_CL];
  logic [CLW-1:0]    tap;

  for (genvar g = 0; g < MAX_CL; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v[0] <= 1'b0;
          d[0] <= '0;
        end else begin
          v[0] <= in_vld;
          d[0] <= in_vld ? in_data : '0;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v[g] <= 1'b0;
          d[g] <= '0;
        end else begin
          v[g] <= v[g-1];
          d[g] <= d[g-1];
        end
      end
    end
  end

  assign tap      = cl_sel - CLW'(1);
  assign out_vld  = v[tap];
  assign out_data = v[tap] ? d[tap] : '0;

endmodule

// File: rtl/sdram_rd_burst_seq.sv
module sdram_rd_burst_seq #(
  parameter int               COL_W  = 8,
  parameter int               DW     = 16,
  parameter int               MIN_CL = 2,
  parameter int               MAX_CL = 3,
  parameter logic [COL_W-1:0] SALT   = 8'h5A,
  localparam int              CLW    = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [COL_W-1:0] rd_col,
  input  logic [CLW-1:0]   cas_lat,
  input  logic [2:0]       burst_code,
  input  logic             interleave,
  input  logic             term,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_col_valid,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);

  logic [CLW-1:0]   cl_q;
  logic [CLW-1:0]   cl_new;
  logic             act_q;
  logic             full_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] mask_q;
  logic [DW-1:0]    rf_word;

  assign cl_new = (int'(cas_lat) < MIN_CL) ? CLW'(MIN_CL) :
                  (int'(cas_lat) > MAX_CL) ? CLW'(MAX_CL) : cas_lat;

  always_ff @(posedge clk) begin
    if (!rst_n)      cl_q <= CLW'(MIN_CL);
    else if (rd_req) cl_q <= cl_new;
  end

  sdram_rd_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_col     (rd_col),
    .burst_code (burst_code),
    .interleave (interleave),
    .term       (term),
    .col_q      (beat_col),
    .vld_q      (beat_col_valid),
    .act_q      (act_q),
    .full_q     (full_q),
    .cnt_q      (cnt_q),
    .mask_q     (mask_q)
  );

  sdram_rd_regfile #(.COL_W(COL_W), .DW(DW), .SALT(SALT)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .raddr (beat_col),
    .rdata (rf_word)
  );

  sdram_rd_pipe #(.DW(DW), .MAX_CL(MAX_CL), .CLW(CLW)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (beat_col_valid),
    .in_data  (rf_word),
    .cl_sel   (cl_q),
    .out_vld  (dq_oe),
    .out_data (dq_out)
  );

endmodule

// File: rtl/sdram_rd_burst_seq_chk.sv
module sdram_rd_burst_seq_chk #(
  parameter int               COL_W = 8,
  parameter int               DW    = 16,
  parameter int               CLW   = 2,
  parameter logic [COL_W-1:0] SALT  = 8'h5A
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic [COL_W-1:0] rd_col,
  input logic             term,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_col_valid,
  input logic [DW-1:0]    dq_out,
  input logic             dq_oe,
  input logic [CLW-1:0]   cl_q,
  input logic             act_q,
  input logic             full_q,
  input logic [COL_W-1:0] cnt_q,
  input logic [COL_W-1:0] mask_q
);

  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (beat_col_valid && beat_col == $past(rd_col)));

  a_r3_lat2_source: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_q == CLW'(2) && dq_oe) |-> $past(beat_col_valid, 2));

  a_r4_word_lat3: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_q == CLW'(3) && dq_oe) |->
      (dq_out == DW'({$past(beat_col, 3) ^ SALT, ~$past(beat_col, 3)})));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !full_q) |-> (cnt_q <= mask_q));

  a_r8_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && beat_col_valid && $past(beat_col_valid) && !$past(rd_req)) |->
      (beat_col == $past(beat_col) + 1'b1));

  a_r9_term_halts: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(term) && !$past(rd_req)) |-> !beat_col_valid);

endmodule

bind sdram_rd_burst_seq sdram_rd_burst_seq_chk #(
  .COL_W(COL_W), .DW(DW), .CLW(CLW), .SALT(SALT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rd_req         (rd_req),
  .rd_col         (rd_col),
  .term           (term),
  .beat_col       (beat_col),
  .beat_col_valid (beat_col_valid),
  .dq_out         (dq_out),
  .dq_oe          (dq_oe),
  .cl_q           (cl_q),
  .act_q          (act_q),
  .full_q         (full_q),
  .cnt_q          (cnt_q),
  .mask_q         (mask_q)
);

// File: tb/sdram_rd_burst_seq_test.sv
module sdram_rd_burst_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [7:0]  rd_col = '0;
  logic [1:0]  cas_lat = 2'd2;
  logic [2:0]  burst_code = '0;
  logic        interleave = 1'b0;
  logic        term = 1'b0;
  logic [7:0]  beat_col;
  logic        beat_col_valid;
  logic [15:0] dq_out;
  logic        dq_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdram_rd_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_col(rd_col),
    .cas_lat(cas_lat), .burst_code(burst_code), .interleave(interleave),
    .term(term), .beat_col(beat_col), .beat_col_valid(beat_col_valid),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // {start, cas, code, ilv, stop, expected beats}
  localparam logic [33:0] VEC [10] = '{
    {8'h35, 2'd3, 3'd3, 1'b0, 10'd0,   10'd8},
    {8'h35, 2'd3, 3'd3, 1'b1, 10'd0,   10'd8},
    {8'h35, 2'd2, 3'd2, 1'b0, 10'd0,   10'd4},
    {8'h3E, 2'd2, 3'd1, 1'b1, 10'd0,   10'd2},
    {8'h80, 2'd3, 3'd0, 1'b0, 10'd0,   10'd1},
    {8'h41, 2'd1, 3'd5, 1'b0, 10'd0,   10'd1},
    {8'hFC, 2'd2, 3'd7, 1'b1, 10'd6,   10'd6},
    {8'h07, 2'd3, 3'd2, 1'b1, 10'd0,   10'd4},
    {8'h10, 2'd3, 3'd3, 1'b0, 10'd3,   10'd3},
    {8'h00, 2'd3, 3'd7, 1'b0, 10'd300, 10'd300}
  };

  function automatic logic [15:0] word_of(input logic [7:0] c);
    return {c ^ 8'h5A, ~c};
  endfunction

  function automatic logic [7:0] col_of(input logic [7:0] st, input logic [2:0] code,
                                         input logic ilv, input int k);
    int len, base, off;
    if (code == 3'd7) return 8'((int'(st) + k) % 256);
    len  = (code <= 3'd3) ? (1 << code) : 1;
    base = int'(st) - (int'(st) % len);
    off  = ilv ? ((int'(st) % len) ^ k) : ((int'(st) % len + k) % len);
    return 8'(base + off);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [7:0] st, input logic [1:0] cl,
                         input logic [2:0] code, input logic ilv,
                         input int stop, input int len);
    int    ecl;
    string oreq;
    ecl  = (cl < 2'd2) ? 2 : int'(cl);
    oreq = (code == 3'd7) ? "R8" : (ilv ? "R7" : "R6");
    @(negedge clk);
    rd_req = 1'b1; rd_col = st; cas_lat = cl; burst_code = code; interleave = ilv;
    @(negedge clk);
    rd_req = 1'b0;
    for (int t = 0; t < len + ecl + 2; t++) begin
      term = (stop > 0 && t == stop - 1);
      chk((stop > 0) ? "R9" : "R5", "beat valid", 32'(beat_col_valid), 32'(t < len));
      if (t < len) chk(oreq, "beat column", 32'(beat_col), 32'(col_of(st, code, ilv, t)));
      chk("R3", "oe window", 32'(dq_oe), 32'(t >= ecl && t - ecl < len));
      if (t >= ecl && t - ecl < len)
        chk("R4", "data word", 32'(dq_out), 32'(word_of(col_of(st, code, ilv, t - ecl))));
      else
        chk("R10", "idle data", 32'(dq_out), 32'h0);
      @(negedge clk);
    end
    term = 1'b0;
  endtask

  localparam logic [7:0] ICOL [5] = '{8'h10, 8'h11, 8'h12, 8'h40, 8'h41};

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset valid", 32'(beat_col_valid), 32'h0);
    chk("R1", "reset oe", 32'(dq_oe), 32'h0);
    chk("R1", "reset data", 32'(dq_out), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", 32'(dq_oe), 32'h0);

    for (int i = 0; i < 10; i++)
      run_vec(VEC[i][33:26], VEC[i][25:24], VEC[i][23:21], VEC[i][20],
              int'(VEC[i][19:10]), int'(VEC[i][9:0]));

    // R11: second read cuts off an 8-beat burst after three beats
    @(negedge clk);
    rd_req = 1'b1; rd_col = 8'h10; cas_lat = 2'd3; burst_code = 3'd3; interleave = 1'b0;
    @(negedge clk);
    rd_req = 1'b0;
    for (int t = 0; t < 10; t++) begin
      if (t == 2) begin rd_req = 1'b1; rd_col = 8'h40; burst_code = 3'd1; end
      else rd_req = 1'b0;
      chk("R11", "cut beat valid", 32'(beat_col_valid), 32'(t < 5));
      if (t < 5) chk("R11", "cut beat column", 32'(beat_col), 32'(ICOL[t]));
      chk("R11", "cut oe", 32'(dq_oe), 32'(t >= 3 && t < 8));
      if (t >= 3 && t < 8) chk("R11", "cut data", 32'(dq_out), 32'(word_of(ICOL[t-3])));
      @(negedge clk);
    end
    rd_req = 1'b0;

    // R1: reset in the middle of a burst
    rd_req = 1'b1; rd_col = 8'h20; cas_lat = 2'd3; burst_code = 3'd3;
    @(negedge clk);
    rd_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < 6; t++) begin
      chk("R1", "flushed beat", 32'(beat_col_valid), 32'h0);
      chk("R1", "flushed oe", 32'(dq_oe), 32'h0);
      @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule